// File: doc/BRIEF.md
# DRAM Nibble-Pair Access Sequencer

This block runs the memory side of one 2 MHz access slot on a DRAM that is four bits wide. A 16 MHz master clock splits each slot into eight phases. Inside one row-strobe low window the block issues two column-strobe pulses, so two nibbles from neighbouring columns are read and joined into one byte. Strobes are registered on the rising clock edge. Address changes, write data and all data capture are registered on the falling edge, so each address reaches the bus half a master cycle before the strobe that latches it.

A slot goes to video when the slot is free, pixel fetching is on and the beam is inside the active line. The non-maskable interrupt input (`nmi_i`) blocks that video access. A blocked slot, or any slot that is not a video slot, carries a CPU two-nibble transfer: a read into `cpu_rdata_o` or a write from `cpu_wdata_i`. A finished video byte is handed to the pixel stage at the end of the slot.

The phase machine has eight one-hot states, PH0 (value 1) through PH7 (value 128). Every clock it steps PH0→PH1→…→PH7, then wraps PH7→PH0. Reset forces PH0. The access decision and the slot's addresses are latched on the PH7→PH0 transition.

Top module: `nibble_pair_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the row strobe, the column strobe and the write strobe are all driven high from that edge on, and the phase returns to PH0. At falling edges with `rst` high, `byte_rdy_o`, `pix_load_o`, `dram_dq_oe_o`, `dram_addr_o`, `pix_byte_o` and `cpu_rdata_o` are cleared.
- R2: The row strobe is low during PH1 to PH6 and high during PH7 and PH0. The column strobe is low during PH2, PH3, PH5 and PH6, which gives two pulses per row window.
- R3: `dram_addr_o` takes the following values, each at the falling edge of the phase named, and is otherwise held:
  - the latched row, at the PH0 falling edge;
  - the latched column, at the PH1 falling edge;
  - the latched column plus one, wrapping modulo 2^AW, at the PH4 falling edge.
- R4: In a video slot, the `dram_dq_i` value at the PH3 falling edge loads byte bits [7:4] and clears bits [3:0]. The value at the PH6 falling edge is ORed into bits [3:0], and `byte_rdy_o` is set.
- R5: At the PH7 falling edge, if `byte_rdy_o` is set, the byte is copied to `pix_byte_o`, `pix_load_o` goes high for one clock and `byte_rdy_o` clears. If `byte_rdy_o` is not set, `pix_load_o` stays low and `pix_byte_o` holds its value.
- R6: On the PH7→PH0 edge:
  - a video slot is chosen only if `slot_free_i`, `fetch_en_i` and `in_line_i` are all high and `nmi_i` is low;
  - otherwise the slot uses `cpu_row_i` and `cpu_col_i`;
  - in a CPU read slot, the nibbles sampled at PH3 and PH6 fill `cpu_rdata_o` [7:4] and [3:0], and `byte_rdy_o` is not set.
- R7: `col_adv_o` is high for the whole of PH0 whenever `slot_free_i`, `fetch_en_i` and `in_line_i` were all high on the PH7→PH0 edge, whatever the value of `nmi_i`.
- R8: In a video slot or a CPU read slot, the write strobe stays high. In a CPU write slot (`cpu_wr_i` high on the PH7→PH0 edge and no video slot chosen):
  - the write strobe is low during PH1 to PH6;
  - `dram_dq_o` carries `cpu_wdata_i`[7:4] from the PH1 falling edge and [3:0] from the PH4 falling edge;
  - `dram_dq_oe_o` is high from the PH0 falling edge to the PH7 falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_free_i | input | 1 | Slot not claimed by another master |
| fetch_en_i | input | 1 | Pixel fetching enabled |
| in_line_i | input | 1 | Beam inside the active line |
| nmi_i | input | 1 | Blocks the video access of the slot |
| cpu_wr_i | input | 1 | CPU slot is a write |
| vid_row_i | input | AW | Video row address |
| vid_col_i | input | AW | Video first column address |
| cpu_row_i | input | AW | CPU row address |
| cpu_col_i | input | AW | CPU first column address |
| cpu_wdata_i | input | 2*DW | CPU write byte |
| dram_dq_i | input | DW | DRAM read nibble |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_addr_o | output | AW | Multiplexed DRAM address |
| dram_dq_o | output | DW | DRAM write nibble |
| dram_dq_oe_o | output | 1 | Write data drive enable |
| col_adv_o | output | 1 | Advance the video column counter |
| byte_rdy_o | output | 1 | Video byte assembled, not yet handed over |
| pix_byte_o | output | 2*DW | Byte for the pixel stage |
| pix_load_o | output | 1 | Pixel stage load pulse |
| cpu_rdata_o | output | 2*DW | CPU read byte |

## Verification
The bench builds the block with its defaults: AW = 8 and DW = 4. With that width a directed video slot at column 8'hFF is cheap, so the second-column wrap to 8'h00 is covered. A byte-wide nibble pair lets every PH3/PH6 capture be compared bit for bit. Directed slots come first: an NMI-blocked slot, a CPU write, and slots lost to each qualifier. Pseudo-random slots follow and mix all of these, so back-to-back video, read and write slots show that the ready flag and the data enable hand off correctly across the PH7→PH0 boundary.

// File: rtl/nps_pkg.sv
package nps_pkg;

    // One-hot slot phases, PH0 = value 1 ... PH7 = value 128
    typedef enum logic [7:0] {
        PH0 = 8'b0000_0001,
        PH1 = 8'b0000_0010,
        PH2 = 8'b0000_0100,
        PH3 = 8'b0000_1000,
        PH4 = 8'b0001_0000,
        PH5 = 8'b0010_0000,
        PH6 = 8'b0100_0000,
        PH7 = 8'b1000_0000
    } phase_e;

    // Row strobe window: the six middle phases of the slot
    function automatic logic row_window(input phase_e p);
        return (p inside {PH1, PH2, PH3, PH4, PH5, PH6});
    endfunction

    // Two column pulses nested in the row window
    function automatic logic col_window(input phase_e p);
        return (p inside {PH2, PH3, PH5, PH6});
    endfunction

endpackage

// File: rtl/nps_phase_fsm.sv
module nps_phase_fsm
    import nps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph,
    output phase_e ph_nxt
);

    phase_e ph_q;

    always_comb begin
        ph_nxt = PH0;
        unique case (ph_q)
            PH0:     ph_nxt = PH1;
            PH1:     ph_nxt = PH2;
            PH2:     ph_nxt = PH3;
            PH3:     ph_nxt = PH4;
            PH4:     ph_nxt = PH5;
            PH5:     ph_nxt = PH6;
            PH6:     ph_nxt = PH7;
            PH7:     ph_nxt = PH0;
            default: ph_nxt = PH0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH0;
        else     ph_q <= ph_nxt;
    end

    assign ph = ph_q;

endmodule

// File: rtl/nps_strobe_gen.sv
module nps_strobe_gen
    import nps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph_nxt,
    input  logic   wr_slot,
    output logic   ras_n,
    output logic   cas_n,
    output logic   we_n
);

    logic ras_d, cas_d, we_d;

    always_comb begin
        ras_d = ~row_window(ph_nxt);
        cas_d = ~col_window(ph_nxt);
        we_d  = ~(wr_slot & row_window(ph_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            ras_n <= ras_d;
            cas_n <= cas_d;
            we_n  <= we_d;
        end
    end

endmodule

// File: rtl/nps_addr_mux.sv
module nps_addr_mux
    import nps_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          ph,
    input  logic [AW-1:0]   row,
    input  logic [AW-1:0]   col,
    input  logic [2*DW-1:0] wdata,
    input  logic            wr_slot,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   dq_o,
    output logic            dq_oe
);

    localparam int BW = 2 * DW;

    logic [AW-1:0] col_next;
    assign col_next = col + AW'(1);

    always_ff @(negedge clk) begin
        if (rst) begin
            addr  <= '0;
            dq_o  <= '0;
            dq_oe <= 1'b0;
        end else begin
            unique case (ph)
                PH0: begin
                    addr  <= row;
                    dq_oe <= wr_slot;
                end
                PH1: begin
                    addr <= col;
                    dq_o <= wdata[BW-1:DW];
                end
                PH4: begin
                    addr <= col_next;
                    dq_o <= wdata[DW-1:0];
                end
                PH7: dq_oe <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nps_nibble_capture.sv
module nps_nibble_capture
    import nps_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          ph,
    input  logic            vid_slot,
    input  logic            wr_slot,
    input  logic [DW-1:0]   dq_i,
    output logic            byte_rdy,
    output logic [2*DW-1:0] pix_byte,
    output logic            pix_load,
    output logic [2*DW-1:0] cpu_rdata
);

    localparam int BW = 2 * DW;

    logic [BW-1:0] asm_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            asm_q     <= '0;
            byte_rdy  <= 1'b0;
            pix_byte  <= '0;
            pix_load  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            pix_load <= 1'b0;
            unique case (ph)
                PH3: begin
                    if (vid_slot)      asm_q <= {dq_i, {DW{1'b0}}};
                    else if (!wr_slot) cpu_rdata[BW-1:DW] <= dq_i;
                end
                PH6: begin
                    if (vid_slot) begin
                        asm_q[DW-1:0] <= asm_q[DW-1:0] | dq_i;
                        byte_rdy      <= 1'b1;
                    end else if (!wr_slot) begin
                        cpu_rdata[DW-1:0] <= dq_i;
                    end
                end
                PH7: begin
                    if (byte_rdy) begin
                        pix_byte <= asm_q;
                        pix_load <= 1'b1;
                        byte_rdy <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nibble_pair_seq.sv
module nibble_pair_seq
    import nps_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_free_i,
    input  logic            fetch_en_i,
    input  logic            in_line_i,
    input  logic            nmi_i,
    input  logic            cpu_wr_i,
    input  logic [AW-1:0]   vid_row_i,
    input  logic [AW-1:0]   vid_col_i,
    input  logic [AW-1:0]   cpu_row_i,
    input  logic [AW-1:0]   cpu_col_i,
    input  logic [2*DW-1:0] cpu_wdata_i,
    input  logic [DW-1:0]   dram_dq_i,
    output logic            dram_ras_n_o,
    output logic            dram_cas_n_o,
    output logic            dram_we_n_o,
    output logic [AW-1:0]   dram_addr_o,
    output logic [DW-1:0]   dram_dq_o,
    output logic            dram_dq_oe_o,
    output logic            col_adv_o,
    output logic            byte_rdy_o,
    output logic [2*DW-1:0] pix_byte_o,
    output logic            pix_load_o,
    output logic [2*DW-1:0] cpu_rdata_o
);

    localparam int BW = 2 * DW;

    phase_e        ph, ph_nxt;
    logic          want_vid, take_vid;
    logic          vid_q, wr_q, adv_q;
    logic [AW-1:0] row_q, col_q;
    logic [BW-1:0] wdata_q;

    assign want_vid = slot_free_i & fetch_en_i & in_line_i;
    assign take_vid = want_vid & ~nmi_i;

    nps_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ph     (ph),
        .ph_nxt (ph_nxt)
    );

    // Slot decision and address capture on the PH7 -> PH0 edge
    always_ff @(posedge clk) begin
        if (rst) begin
            vid_q   <= 1'b0;
            wr_q    <= 1'b0;
            adv_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else if (ph == PH7) begin
            vid_q   <= take_vid;
            wr_q    <= ~take_vid & cpu_wr_i;
            adv_q   <= want_vid;
            row_q   <= take_vid ? vid_row_i : cpu_row_i;
            col_q   <= take_vid ? vid_col_i : cpu_col_i;
            wdata_q <= cpu_wdata_i;
        end else begin
            adv_q <= 1'b0;
        end
    end

    assign col_adv_o = adv_q;

    nps_strobe_gen u_strobe (
        .clk     (clk),
        .rst     (rst),
        .ph_nxt  (ph_nxt),
        .wr_slot (wr_q),
        .ras_n   (dram_ras_n_o),
        .cas_n   (dram_cas_n_o),
        .we_n    (dram_we_n_o)
    );

    nps_addr_mux #(.AW(AW), .DW(DW)) u_amux (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .row     (row_q),
        .col     (col_q),
        .wdata   (wdata_q),
        .wr_slot (wr_q),
        .addr    (dram_addr_o),
        .dq_o    (dram_dq_o),
        .dq_oe   (dram_dq_oe_o)
    );

    nps_nibble_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .vid_slot  (vid_q),
        .wr_slot   (wr_q),
        .dq_i      (dram_dq_i),
        .byte_rdy  (byte_rdy_o),
        .pix_byte  (pix_byte_o),
        .pix_load  (pix_load_o),
        .cpu_rdata (cpu_rdata_o)
    );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic          pix_load,
    input logic          byte_rdy
);

    // R1: reset parks every strobe high
    p_reset_strobes_r1: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n));

    // R2: column strobe only inside the row window
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    // R2: row strobe falls one phase before the first column pulse
    p_ras_leads_cas_r2: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(ras_n)) |-> (cas_n ##1 !cas_n));

    // R3: address held while the column strobe is low
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> $stable(addr));

    // R8: write strobe only inside the row window
    p_we_in_ras_r8: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ras_n);

    // R5: handing a byte over clears the ready flag
    p_load_clears_ready_r5: assert property (@(posedge clk) disable iff (rst)
        pix_load |-> !byte_rdy);

endmodule

bind nibble_pair_seq nps_checker #(.AW(AW)) u_nps_checker (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (dram_ras_n_o),
    .cas_n    (dram_cas_n_o),
    .we_n     (dram_we_n_o),
    .addr     (dram_addr_o),
    .pix_load (pix_load_o),
    .byte_rdy (byte_rdy_o)
);

// File: tb/nibble_pair_seq_tb.sv
module nibble_pair_seq_tb;

    localparam int AW = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slot_free_i = 0, fetch_en_i = 0, in_line_i = 0, nmi_i = 0, cpu_wr_i = 0;
    logic [AW-1:0] vid_row_i = 0, vid_col_i = 0, cpu_row_i = 0, cpu_col_i = 0;
    logic [7:0]    cpu_wdata_i = 0;
    logic [DW-1:0] dram_dq_i = 0;
    logic          dram_ras_n_o, dram_cas_n_o, dram_we_n_o, dram_dq_oe_o;
    logic [AW-1:0] dram_addr_o;
    logic [DW-1:0] dram_dq_o;
    logic          col_adv_o, byte_rdy_o, pix_load_o;
    logic [7:0]    pix_byte_o, cpu_rdata_o;

    nibble_pair_seq #(.AW(AW), .DW(DW)) u_dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int         m_ph = 0;
    bit         m_vid = 0, m_wr = 0, m_adv = 0;
    bit         m_ras = 1, m_cas = 1, m_we = 1, m_oe = 0, m_rdy = 0, m_load = 0;
    logic [7:0] m_row = 0, m_col = 0, m_wd = 0, m_addr = 0;
    logic [7:0] m_byte = 0, m_pix = 0, m_crd = 0;
    logic [3:0] m_dq = 0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    function automatic bit in_row(input int p);
        return (p >= 1 && p <= 6);
    endfunction

    task automatic model_pos();
        if (rst) begin
            m_ph = 0; m_ras = 1; m_cas = 1; m_we = 1;
            m_vid = 0; m_wr = 0; m_adv = 0; m_row = 0; m_col = 0; m_wd = 0;
        end else begin
            bit want;
            want = slot_free_i && fetch_en_i && in_line_i;
            if (m_ph == 7) begin
                m_vid = want && !nmi_i;
                m_wr  = !m_vid && cpu_wr_i;
                m_adv = want;
                m_row = m_vid ? vid_row_i : cpu_row_i;
                m_col = m_vid ? vid_col_i : cpu_col_i;
                m_wd  = cpu_wdata_i;
            end else begin
                m_adv = 0;
            end
            m_ph  = (m_ph + 1) % 8;
            m_ras = !in_row(m_ph);
            m_cas = !(m_ph == 2 || m_ph == 3 || m_ph == 5 || m_ph == 6);
            m_we  = !(m_wr && in_row(m_ph));
        end
        chk("R1/R2 ras_n", dram_ras_n_o, m_ras);
        chk("R1/R2 cas_n", dram_cas_n_o, m_cas);
        chk("R1/R8 we_n", dram_we_n_o, m_we);
        chk("R7 col_adv", col_adv_o, m_adv);
    endtask

    task automatic model_neg();
        if (rst) begin
            m_addr = 0; m_dq = 0; m_oe = 0; m_byte = 0; m_rdy = 0;
            m_pix = 0; m_load = 0; m_crd = 0;
        end else begin
            m_load = 0;
            case (m_ph)
                0: begin m_addr = m_row; m_oe = m_wr; end
                1: begin m_addr = m_col; m_dq = m_wd[7:4]; end
                3: if (m_vid) m_byte = {dram_dq_i, 4'h0};
                   else if (!m_wr) m_crd[7:4] = dram_dq_i;
                4: begin m_addr = m_col + 8'd1; m_dq = m_wd[3:0]; end
                6: if (m_vid) begin m_byte[3:0] = m_byte[3:0] | dram_dq_i; m_rdy = 1; end
                   else if (!m_wr) m_crd[3:0] = dram_dq_i;
                7: begin
                    m_oe = 0;
                    if (m_rdy) begin m_pix = m_byte; m_load = 1; m_rdy = 0; end
                end
                default: ;
            endcase
        end
        chk("R1/R3 addr", dram_addr_o, m_addr);
        chk("R8 dq_o", dram_dq_o, m_dq);
        chk("R1/R8 dq_oe", dram_dq_oe_o, m_oe);
        chk("R1/R4 byte_rdy", byte_rdy_o, m_rdy);
        chk("R1/R5 pix_byte", pix_byte_o, m_pix);
        chk("R1/R5 pix_load", pix_load_o, m_load);
        chk("R1/R6 cpu_rdata", cpu_rdata_o, m_crd);
    endtask

    // slot stimulus: directed first, then pseudo-random
    task automatic drive_slot(input int s);
        int unsigned r;
        r = rnd();
        vid_row_i   = 8'(rnd());
        vid_col_i   = 8'(rnd());
        cpu_row_i   = 8'(rnd());
        cpu_col_i   = 8'(rnd());
        cpu_wdata_i = 8'(rnd());
        case (s)
            0: begin {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b11100; vid_col_i = 8'hFF; end // R3 wrap, R4
            1: {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b11110;   // R6/R7 blocked by NMI
            2: {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b01001;   // R8 CPU write
            3: {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b11000;   // R6 off-line
            4: {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b10100;   // R6 fetch off
            5: {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b11101;   // R8 write ignored in video slot
            6: begin {slot_free_i, fetch_en_i, in_line_i, nmi_i, cpu_wr_i} = 5'b11111; cpu_col_i = 8'hFF; end
            default: begin
                slot_free_i = r[0] | r[1];
                fetch_en_i  = r[2] | r[3];
                in_line_i   = r[4] | r[5];
                nmi_i       = r[6] & r[7];
                cpu_wr_i    = r[8];
            end
        endcase
    endtask

    initial begin
        int slot;
        slot = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #3 model_pos();
            @(negedge clk); #3 model_neg();
        end
        #3 rst = 0;
        for (int c = 0; c < 3200; c++) begin
            @(posedge clk); #3 model_pos();
            @(negedge clk); #3 model_neg();
            #3 dram_dq_i = 4'(rnd());
            if (m_ph == 7) begin
                drive_slot(slot);
                slot++;
            end
            if (c == 1500) rst = 1;        // R1 mid-run reset
            if (c == 1503) rst = 0;
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule